// File: doc/BRIEF.md
# Serial-Loaded Switch Control Register

The block turns a slow serial bit stream into eight independent on/off enables for a bank of external switches. A host sends bits on a serial data line and marks each one with a rising edge of a serial shift clock. The bits go into a shift register, one stage at a time. A level-sensitive latch sits between that register and the enable outputs. While the latch-enable input is low, the latch is transparent and the enables track the register. While it is high, the enables are frozen. A clear input forces every enable off, whatever the other inputs do. The last shift stage is also driven out on a serial output, so that several blocks can be chained.

The serial clock, serial data, latch enable and clear all come from outside the system clock domain. Each is passed through its own two-flop synchroniser. The rising edge of the serial clock is found by comparing the synchronised value with its value one cycle earlier, so all state in the block changes on the system clock only. The system clock must run at least eight times faster than the serial clock.

The normal load sequence is to raise latch enable, clock in all eight bits, and then lower latch enable. Half-loaded values therefore never reach the switches.

Top module: `swctl_top`

## Requirements
- R1: On each rising edge of the serial clock, the serial data bit is captured into stage 0. At the same time, each stage k moves into stage k+1 (k = 0..6). Without a rising edge the register holds its contents.
- R2: While latch enable is low and clear is low, enable output i equals shift stage i.
- R3: While latch enable is high and clear is low, the enable outputs keep the value they had when latch enable rose. Shifting during this time does not change them.
- R4: While clear is high, all eight enable outputs are 0, whatever latch enable and the serial inputs do. Clear does not alter the shift register contents.
- R5: If clear falls while latch enable is low, the outputs show the shift register contents again. If clear falls while latch enable is high, the outputs stay 0 until latch enable goes low.
- R6: The serial output is high exactly when shift stage 7 holds a 1. A second block fed from it receives the first block's bits in order, eight edges later.
- R7: A 1 in a stage turns the matching switch on (output high) and a 0 turns it off, independently per bit. After eight shift edges, the first bit sent drives output 7 and the last bit sent drives output 0.
- R8: While reset is asserted and right after it is released, the enable outputs are 0 and the serial output is 0.
- R9: A change on any serial-side input is visible at the outputs no more than 5 system clock cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it must run at least 8 times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock; data is shifted in on its rising edge |
| ser_din | input | 1 | Serial data in |
| lat_en | input | 1 | Latch enable: low = outputs transparent, high = outputs held |
| clr | input | 1 | Clear: high forces all enables off |
| sw_en | output | NUM_SW | Switch enables, one per switch, 1 = on |
| ser_dout | output | 1 | Copy of the last shift stage, used for chaining |

## Verification
The bench targets bit order first. It sends a single leading 1 followed by zeros. A design that shifts the wrong way would light output 0 instead of output 7.

It also shifts with latch enable held high and with clear held high. A leaky latch or a clear that wipes the register would show changed enables, or would show zeros after clear is released with latch enable low.

The bench releases clear under both latch-enable levels. A design that re-opens the latch on clear release would show register data where zeros are required.

Finally, it checks the serial output after a full second byte has been shifted. It also measures the delay from a latch-enable change to the outputs, which would expose a missing or extra pipeline stage.

// File: rtl/swctl_pkg.sv
`timescale 1ns/1ps
package swctl_pkg;
    // index of each asynchronous input inside the synchroniser bank
    typedef enum int unsigned {
        CH_SCLK = 0,
        CH_LE   = 1,
        CH_CLR  = 2,
        CH_DIN  = 3
    } sync_ch_e;

    localparam int unsigned NUM_CH = 4;
endpackage

// File: rtl/swctl_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser with a rising-edge detector on the synchronised level.
module swctl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = st_q.chain[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/swctl_shift.sv
`timescale 1ns/1ps
// Serial-in parallel-out register: new bit enters stage 0, older bits move up.
module swctl_shift #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] stages_o
);
    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {st_q.sr[WIDTH-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stages_o = st_q.sr;
endmodule

// File: rtl/swctl_latch.sv
`timescale 1ns/1ps
// Level-sensitive output latch realised as a clocked register, clear has priority.
module swctl_latch #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             force_off,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] held;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (force_off) begin
            st_d.held = '0;
        end else if (!hold) begin
            st_d.held = d_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.held;
endmodule

// File: rtl/swctl_top.sv
`timescale 1ns/1ps
module swctl_top #(
    parameter int unsigned NUM_SW      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              lat_en,
    input  logic              clr,
    output logic [NUM_SW-1:0] sw_en,
    output logic              ser_dout
);
    import swctl_pkg::*;

    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] lvl;
    logic [NUM_CH-1:0] rise;

    assign raw_in[CH_SCLK] = ser_clk;
    assign raw_in[CH_LE]   = lat_en;
    assign raw_in[CH_CLR]  = clr;
    assign raw_in[CH_DIN]  = ser_din;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sync
        swctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[g]),
            .level_o  (lvl[g]),
            .rise_o   (rise[g])
        );
    end

    logic shift_pulse;
    logic din_lvl;
    logic le_lvl;
    logic clr_lvl;
    logic unused_edges;

    assign shift_pulse  = rise[CH_SCLK];
    assign din_lvl      = lvl[CH_DIN];
    assign le_lvl       = lvl[CH_LE];
    assign clr_lvl      = lvl[CH_CLR];
    assign unused_edges = ^{rise[CH_LE], rise[CH_CLR], rise[CH_DIN], lvl[CH_SCLK]};

    logic [NUM_SW-1:0] shreg_q;

    swctl_shift #(.WIDTH(NUM_SW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_pulse),
        .bit_in   (din_lvl),
        .stages_o (shreg_q)
    );

    swctl_latch #(.WIDTH(NUM_SW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (le_lvl),
        .force_off (clr_lvl),
        .d_i       (shreg_q),
        .q_o       (sw_en)
    );

    assign ser_dout = shreg_q[NUM_SW-1];
endmodule

// File: rtl/swctl_checker.sv
`timescale 1ns/1ps
module swctl_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         shift_pulse,
    input logic         din_lvl,
    input logic         le_lvl,
    input logic         clr_lvl,
    input logic [W-1:0] shreg_q,
    input logic [W-1:0] sw_en
);
    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> (shreg_q[0] == $past(din_lvl)) &&
                        (shreg_q[W-1:1] == $past(shreg_q[W-2:0]))); // R1

    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_pulse |=> $stable(shreg_q)); // R1

    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_lvl && !clr_lvl) |=> (sw_en == $past(shreg_q))); // R2

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (le_lvl && !clr_lvl) |=> $stable(sw_en)); // R3

    AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lvl |=> (sw_en == '0)); // R4
endmodule

bind swctl_top swctl_checker #(.W(NUM_SW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_pulse (shift_pulse),
    .din_lvl     (din_lvl),
    .le_lvl      (le_lvl),
    .clr_lvl     (clr_lvl),
    .shreg_q     (shreg_q),
    .sw_en       (sw_en)
);

// File: tb/swctl_top_test.sv
`timescale 1ns/1ps
module swctl_top_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_din = 1'b0;
    logic         lat_en = 1'b0;
    logic         clr = 1'b0;
    logic [W-1:0] sw_en;
    logic         ser_dout;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [W-1:0] m_sr = '0;
    logic [W-1:0] m_out = '0;
    logic         m_le = 1'b0;
    logic         m_clr = 1'b0;

    swctl_top uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .lat_en(lat_en), .clr(clr), .sw_en(sw_en), .ser_dout(ser_dout)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] next_out(logic [W-1:0] held, logic [W-1:0] sr,
                                              logic le, logic c);
        if (c) return '0;
        if (!le) return sr;
        return held;
    endfunction

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_out(string tag, logic [W-1:0] exp);
        n_checks++;
        if (sw_en !== exp) begin
            n_fail++;
            $display("FAIL %s sw_en actual=%h expected=%h", tag, sw_en, exp);
        end
    endtask

    task automatic check_dout(string tag, logic exp);
        n_checks++;
        if (ser_dout !== exp) begin
            n_fail++;
            $display("FAIL %s ser_dout actual=%b expected=%b", tag, ser_dout, exp);
        end
    endtask

    task automatic shift_bit(logic b);
        @(negedge clk);
        ser_din = b;
        wait_clks(4);
        ser_clk = 1'b1;
        wait_clks(4);
        ser_clk = 1'b0;
        wait_clks(4);
        m_sr  = {m_sr[W-2:0], b};
        m_out = next_out(m_out, m_sr, m_le, m_clr);
        wait_clks(3);
    endtask

    task automatic shift_byte(logic [W-1:0] v);
        for (int i = W - 1; i >= 0; i--) shift_bit(v[i]);
    endtask

    task automatic set_le(logic v);
        @(negedge clk);
        lat_en = v;
        m_le   = v;
        m_out  = next_out(m_out, m_sr, m_le, m_clr);
        wait_clks(6);
    endtask

    task automatic set_clr(logic v);
        @(negedge clk);
        clr   = v;
        m_clr = v;
        m_out = next_out(m_out, m_sr, m_le, m_clr);
        wait_clks(6);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));

        // R8: reset state
        wait_clks(3);
        check_out("R8 in reset", '0);
        check_dout("R8 in reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_clks(2);
        check_out("R8 after reset", '0);
        check_dout("R8 after reset", 1'b0);

        // R7: bit order, shifting with latch enable high
        set_le(1'b1);
        shift_byte(8'h80);
        check_out("R3 shifting while held", '0);
        set_le(1'b0);
        check_out("R7 first bit drives output 7", 8'h80);

        // R9: latch enable low to outputs within 5 cycles
        set_le(1'b1);
        shift_byte(8'h3C);
        @(negedge clk);
        lat_en = 1'b0;
        m_le   = 1'b0;
        m_out  = next_out(m_out, m_sr, m_le, m_clr);
        wait_clks(5);
        check_out("R9 latency of latch enable", 8'h3C);
        wait_clks(2);

        // R2: transparent path follows each shift
        shift_bit(1'b1);
        check_out("R2 transparent follow", m_out);
        check_out("R2 transparent value", 8'h79);

        // R3: rising latch enable holds, shifting has no effect
        set_le(1'b1);
        shift_byte(8'hA5);
        check_out("R3 hold across byte", 8'h79);

        // R6: serial out shows stage 7 (0xA5 -> bit 7 is 1), and chained byte order
        check_dout("R6 stage 7 high", 1'b1);
        shift_bit(1'b0);
        check_dout("R6 stage 7 after shift", 1'b0);
        set_le(1'b0);
        check_out("R7 independent bits", 8'h4A);

        // R4: clear overrides, register kept
        set_clr(1'b1);
        check_out("R4 clear forces off", '0);
        shift_bit(1'b1);
        check_out("R4 clear during shift", '0);
        set_le(1'b1);
        set_le(1'b0);
        check_out("R4 clear beats latch enable", '0);

        // R5: release with latch enable low restores register (0x95)
        set_clr(1'b0);
        check_out("R4 register kept under clear", 8'h95);
        check_out("R5 release le low", m_out);

        // R5: release with latch enable high stays off
        set_le(1'b1);
        set_clr(1'b1);
        set_clr(1'b0);
        check_out("R5 release le high stays off", '0);
        set_le(1'b0);
        check_out("R5 le low after release", 8'h95);

        // constrained random mix
        for (int k = 0; k < 300; k++) begin
            int unsigned op;
            op = $urandom % 8;
            case (op)
                0, 1, 2, 3: shift_bit(1'($urandom));
                4, 5:       set_le(~m_le);
                default:    set_clr((($urandom % 3) == 0) ? 1'b1 : 1'b0);
            endcase
            if (m_clr)      check_out("R4 random", m_out);
            else if (m_le)  check_out("R3 random", m_out);
            else            check_out("R2 random", m_out);
            check_dout("R6 random", m_sr[W-1]);
        end

        finish_run();
    end
endmodule